// File: doc/BRIEF.md
# Strided Load-Store Offset Generator

This block rewrites the displacement immediate of a vectorised load or store so that each element of the vector reaches its own address. For every element the surrounding loop supplies the element and sub-element steps, the sub-vector length, the access width and the raw immediate field. The block turns these into a 32-bit displacement and a flag that says whether the displacement replaces the one decoded from the instruction. Adding the displacement to a base register and performing the memory access happen downstream.

The step multiplier comes from the source step for loads and from the destination step for stores. A load may instead take an externally supplied element index, which lets a reordering unit place elements. The immediate is read as a 16-bit field, as a 14-bit word-scaled field, or as an 11-bit field for the shifted mode. It is then scaled by the stride rule of the selected mode. The result is registered, so it appears one cycle after the request.

Top module: `stride_disp_gen`

## Requirements
- R1: The multiplier is step*(subvl+1)+sub_step, using src_step_i when op_i is 1 (load) and dst_step_i when op_i is 2 (store). For op_i of 0 or 3 the multiplier is 0.
- R2: When ovr_vld_i is 1 and op_i is 1 (load), ovr_idx_i is used as the multiplier. For any other op_i, ovr_vld_i has no effect.
- R3: Outside mode 3, imm_i is sign-extended from 16 bits when ds_i is 0. When ds_i is 1, imm_i[13:0] is multiplied by 4 and the result is sign-extended as 16 bits.
- R4: Mode 3 (shifted) sign-extends imm_i[10:0]. The result is (imm*multiplier) shifted left by shamt_i, truncated to 32 bits.
- R5: Mode 1 (unit-strided) gives imm + multiplier*width_i, truncated to 32 bits.
- R6: Mode 2 (element-strided) gives imm*multiplier, truncated to 32 bits.
- R7: Mode 0 (plain) outputs the extended immediate with replace_o at 0. Modes 1, 2 and 3 set replace_o to 1.
- R8: When replace_o is 1 and ds_i is 1, the 32-bit result is shifted right logically by 2 before it is output.
- R9: Outputs are registered. valid_o equals valid_i of the previous cycle, and disp_o and replace_o describe the request accepted on that edge. After reset, valid_o, disp_o and replace_o are 0.
- R10: In a cycle where valid_i is 0, disp_o and replace_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| imm_i | input | 16 | Raw immediate field |
| ds_i | input | 1 | Word-scaled immediate format |
| mode_i | input | 2 | 0 plain, 1 unit-strided, 2 element-strided, 3 shifted |
| op_i | input | 2 | 1 load, 2 store, 0 or 3 other |
| src_step_i | input | 7 | Source element step |
| dst_step_i | input | 7 | Destination element step |
| sub_step_i | input | 2 | Sub-element step |
| subvl_i | input | 2 | Sub-vector length minus one |
| ovr_idx_i | input | 9 | Element index override |
| ovr_vld_i | input | 1 | Override valid |
| width_i | input | 4 | Access width in bytes |
| shamt_i | input | 5 | Shift amount for mode 3 |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| disp_o | output | 32 | Replacement displacement |
| replace_o | output | 1 | Displacement replaces the decoded one |

## Verification
The assertions assume that the reset is released before the first request and that every input is defined in any cycle where valid_i is high. They also treat ds_i as a format tag that stays meaningful in the shifted mode as well. The stimulus drives every field from $urandom over its full range on falling edges, which keeps each input settled well before the capturing edge. Randomly placed idle cycles exercise the hold behaviour. Directed cases add negative immediates, the maximum shift and an override presented on a store.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_UNIT  = 2'd1,
    MODE_ELEM  = 2'd2,
    MODE_SHIFT = 2'd3
  } smode_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_RSVD  = 2'd3
  } sop_e;
endpackage

// File: rtl/sdg_mul.sv
module sdg_mul
  import sdg_pkg::*;
#(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int MUL_W  = STEP_W + SUB_W
) (
  input  sop_e              op_i,
  input  logic [STEP_W-1:0] src_step_i,
  input  logic [STEP_W-1:0] dst_step_i,
  input  logic [SUB_W-1:0]  sub_step_i,
  input  logic [SUB_W-1:0]  subvl_i,
  input  logic [MUL_W-1:0]  ovr_idx_i,
  input  logic              ovr_vld_i,
  output logic [MUL_W-1:0]  mul_o
);
  logic [MUL_W-1:0] step_sel;
  logic [MUL_W-1:0] lanes;
  logic [MUL_W-1:0] linear;

  always_comb begin
    step_sel = (op_i == OP_STORE) ? MUL_W'(dst_step_i) : MUL_W'(src_step_i);
    lanes    = MUL_W'(subvl_i) + MUL_W'(1);
    linear   = step_sel * lanes + MUL_W'(sub_step_i);
    unique case (op_i)
      OP_LOAD:  mul_o = ovr_vld_i ? ovr_idx_i : linear;
      OP_STORE: mul_o = linear;
      default:  mul_o = '0;
    endcase
  end
endmodule

// File: rtl/sdg_imm.sv
module sdg_imm #(
  parameter int IMM_W  = 16,
  parameter int SHF_W  = 11,
  parameter int DISP_W = 32
) (
  input  logic [IMM_W-1:0]  raw_i,
  input  logic              ds_i,
  input  logic              shift_form_i,
  output logic [DISP_W-1:0] imm_o
);
  localparam int PAD_W = DISP_W - IMM_W;
  localparam int SPD_W = DISP_W - SHF_W;

  logic [IMM_W-1:0] field;

  always_comb begin
    field = ds_i ? {raw_i[IMM_W-3:0], 2'b00} : raw_i;
    if (shift_form_i) imm_o = {{SPD_W{raw_i[SHF_W-1]}}, raw_i[SHF_W-1:0]};
    else              imm_o = {{PAD_W{field[IMM_W-1]}}, field};
  end
endmodule

// File: rtl/sdg_calc.sv
module sdg_calc
  import sdg_pkg::*;
#(
  parameter int DISP_W = 32,
  parameter int MUL_W  = 9,
  parameter int WID_W  = 4,
  parameter int SH_W   = 5
) (
  input  smode_e            mode_i,
  input  logic              ds_i,
  input  logic [DISP_W-1:0] imm_i,
  input  logic [MUL_W-1:0]  mul_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [DISP_W-1:0] disp_o,
  output logic              replace_o
);
  logic [DISP_W-1:0] mul_x;
  logic [DISP_W-1:0] prod;
  logic [DISP_W-1:0] raw;

  // low DISP_W bits of a product are sign-agnostic
  always_comb begin
    mul_x = DISP_W'(mul_i);
    prod  = imm_i * mul_x;
    unique case (mode_i)
      MODE_UNIT:  raw = imm_i + mul_x * DISP_W'(width_i);
      MODE_ELEM:  raw = prod;
      MODE_SHIFT: raw = prod << shamt_i;
      default:    raw = imm_i;
    endcase
    replace_o = (mode_i != MODE_PLAIN);
    disp_o    = (replace_o && ds_i) ? (raw >> 2) : raw;
  end
endmodule

// File: rtl/stride_disp_gen.sv
module stride_disp_gen
  import sdg_pkg::*;
#(
  parameter int IMM_W  = 16,
  parameter int SHF_W  = 11,
  parameter int DISP_W = 32,
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int WID_W  = 4,
  parameter int SH_W   = 5,
  localparam int MUL_W = STEP_W + SUB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              ds_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        op_i,
  input  logic [STEP_W-1:0] src_step_i,
  input  logic [STEP_W-1:0] dst_step_i,
  input  logic [SUB_W-1:0]  sub_step_i,
  input  logic [SUB_W-1:0]  subvl_i,
  input  logic [MUL_W-1:0]  ovr_idx_i,
  input  logic              ovr_vld_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic              valid_o,
  output logic [DISP_W-1:0] disp_o,
  output logic              replace_o
);
  smode_e            mode;
  sop_e              op;
  logic [MUL_W-1:0]  mul;
  logic [DISP_W-1:0] imm_x;
  logic [DISP_W-1:0] disp_d;
  logic              repl_d;

  assign mode = smode_e'(mode_i);
  assign op   = sop_e'(op_i);

  sdg_mul #(.STEP_W(STEP_W), .SUB_W(SUB_W), .MUL_W(MUL_W)) u_mul (
    .op_i       (op),
    .src_step_i (src_step_i),
    .dst_step_i (dst_step_i),
    .sub_step_i (sub_step_i),
    .subvl_i    (subvl_i),
    .ovr_idx_i  (ovr_idx_i),
    .ovr_vld_i  (ovr_vld_i),
    .mul_o      (mul)
  );

  sdg_imm #(.IMM_W(IMM_W), .SHF_W(SHF_W), .DISP_W(DISP_W)) u_imm (
    .raw_i        (imm_i),
    .ds_i         (ds_i),
    .shift_form_i (mode == MODE_SHIFT),
    .imm_o        (imm_x)
  );

  sdg_calc #(.DISP_W(DISP_W), .MUL_W(MUL_W), .WID_W(WID_W), .SH_W(SH_W)) u_calc (
    .mode_i    (mode),
    .ds_i      (ds_i),
    .imm_i     (imm_x),
    .mul_i     (mul),
    .width_i   (width_i),
    .shamt_i   (shamt_i),
    .disp_o    (disp_d),
    .replace_o (repl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      disp_o    <= '0;
      replace_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        disp_o    <= disp_d;
        replace_o <= repl_d;
      end
    end
  end
endmodule

// File: rtl/stride_disp_chk.sv
module stride_disp_chk #(
  parameter int IMM_W  = 16,
  parameter int DISP_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              ds_i,
  input logic [1:0]        mode_i,
  input logic              valid_o,
  input logic [DISP_W-1:0] disp_o,
  input logic              replace_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  // R9
  a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    valid_o == $past(valid_i));

  // R7
  a_r7_replace: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    valid_o |-> (replace_o == ($past(mode_i) != 2'd0)));

  // R8
  a_r8_ds_top_clear: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    (valid_o && replace_o && $past(ds_i)) |-> (disp_o[DISP_W-1:DISP_W-2] == 2'b00));

  // R3
  a_r3_plain_sext: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    (valid_o && $past(mode_i) == 2'd0 && !$past(ds_i)) |->
      (disp_o == {{(DISP_W-IMM_W){$past(imm_i[IMM_W-1])}}, $past(imm_i)}));

  // R10
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    !$past(valid_i) |-> ($stable(disp_o) && $stable(replace_o)));
endmodule

bind stride_disp_gen stride_disp_chk #(.IMM_W(IMM_W), .DISP_W(DISP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .imm_i     (imm_i),
  .ds_i      (ds_i),
  .mode_i    (mode_i),
  .valid_o   (valid_o),
  .disp_o    (disp_o),
  .replace_o (replace_o)
);

// File: tb/sim_stride_disp_gen.sv
`timescale 1ns/1ps
module sim_stride_disp_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] imm_i = '0;
  logic        ds_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [1:0]  op_i = '0;
  logic [6:0]  src_step_i = '0;
  logic [6:0]  dst_step_i = '0;
  logic [1:0]  sub_step_i = '0;
  logic [1:0]  subvl_i = '0;
  logic [8:0]  ovr_idx_i = '0;
  logic        ovr_vld_i = 1'b0;
  logic [3:0]  width_i = '0;
  logic [4:0]  shamt_i = '0;
  logic        valid_o;
  logic [31:0] disp_o;
  logic        replace_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stride_disp_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .imm_i(imm_i), .ds_i(ds_i),
    .mode_i(mode_i), .op_i(op_i), .src_step_i(src_step_i), .dst_step_i(dst_step_i),
    .sub_step_i(sub_step_i), .subvl_i(subvl_i), .ovr_idx_i(ovr_idx_i),
    .ovr_vld_i(ovr_vld_i), .width_i(width_i), .shamt_i(shamt_i),
    .valid_o(valid_o), .disp_o(disp_o), .replace_o(replace_o)
  );

  function automatic int ref_mul();
    int s;
    if (op_i == 2'd1 && ovr_vld_i) return int'(ovr_idx_i);
    if (op_i == 2'd1) s = int'(src_step_i);
    else if (op_i == 2'd2) s = int'(dst_step_i);
    else return 0;
    return s * (int'(subvl_i) + 1) + int'(sub_step_i);
  endfunction

  function automatic logic [31:0] ref_disp();
    int imm;
    int m;
    logic [31:0] r;
    logic [15:0] f;
    m = ref_mul();
    if (mode_i == 2'd3) imm = int'($signed(imm_i[10:0]));
    else begin
      f = ds_i ? {imm_i[13:0], 2'b00} : imm_i;
      imm = int'($signed(f));
    end
    case (mode_i)
      2'd1: r = 32'(imm + m * int'(width_i));
      2'd2: r = 32'(imm * m);
      2'd3: r = 32'(imm * m) << shamt_i;
      default: r = 32'(imm);
    endcase
    if (mode_i != 2'd0 && ds_i) r = r >> 2;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of();
    if (op_i == 2'd1 && ovr_vld_i) return "R2";
    if (ds_i) return (mode_i != 2'd0) ? "R8" : "R3";
    case (mode_i)
      2'd1: return "R5";
      2'd2: return "R6";
      2'd3: return "R4";
      default: return "R7";
    endcase
  endfunction

  // inputs already set after a negedge; result sampled one negedge later
  task automatic issue(input string tag);
    logic [31:0] e;
    logic        er;
    e  = ref_disp();
    er = (mode_i != 2'd0);
    valid_i = 1'b1;
    @(negedge clk);
    chk("R9 valid", 32'(valid_o), 32'd1);
    chk(tag, disp_o, e);
    chk("R7 replace", 32'(replace_o), 32'(er));
  endtask

  task automatic set_fields(input logic [15:0] im, input logic ds, input logic [1:0] md,
                            input logic [1:0] op, input logic [6:0] ss, input logic [6:0] ds_s,
                            input logic [1:0] sb, input logic [1:0] sv, input logic [8:0] oi,
                            input logic ov, input logic [3:0] w, input logic [4:0] sh);
    imm_i = im; ds_i = ds; mode_i = md; op_i = op; src_step_i = ss; dst_step_i = ds_s;
    sub_step_i = sb; subvl_i = sv; ovr_idx_i = oi; ovr_vld_i = ov; width_i = w; shamt_i = sh;
  endtask

  task automatic randomize_fields();
    set_fields(16'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), 7'($urandom),
               7'($urandom), 2'($urandom), 2'($urandom), 9'($urandom), 1'($urandom),
               4'($urandom), 5'($urandom));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd914));
    repeat (3) @(negedge clk);
    chk("R9 reset valid", 32'(valid_o), 32'd0);
    chk("R9 reset disp", disp_o, 32'd0);
    chk("R9 reset replace", 32'(replace_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5: D-form -16, load src 3, subvl 1, sub 1 -> mul 7, width 8 -> 40
    set_fields(16'hFFF0, 0, 2'd1, 2'd1, 7'd3, 7'd0, 2'd1, 2'd1, 9'd0, 0, 4'd8, 5'd0);
    issue("R5 unit");
    chk("R5 unit const", disp_o, 32'h0000_0028);
    // R8/R6: DS field all ones -> -4, store dst 2 -> -8, >>2 logical
    set_fields(16'h3FFF, 1, 2'd2, 2'd2, 7'd9, 7'd2, 2'd0, 2'd0, 9'd0, 0, 4'd0, 5'd0);
    issue("R8 ds elem");
    chk("R8 ds const", disp_o, 32'h3FFF_FFFE);
    // R4/R2: 11-bit -1, load override 5, shift 3 -> -40
    set_fields(16'h07FF, 0, 2'd3, 2'd1, 7'd1, 7'd0, 2'd0, 2'd0, 9'd5, 1, 4'd0, 5'd3);
    issue("R4 shift ovr");
    chk("R2 ovr const", disp_o, 32'hFFFF_FFD8);
    // R2: override ignored on store: dst 4 -> mul 4, imm 3 -> 12
    set_fields(16'h0003, 0, 2'd2, 2'd2, 7'd0, 7'd4, 2'd0, 2'd0, 9'd100, 1, 4'd0, 5'd0);
    issue("R2 store ignores ovr");
    chk("R2 store const", disp_o, 32'd12);
    // R1: op none -> mul 0, unit mode gives imm
    set_fields(16'h0123, 0, 2'd1, 2'd0, 7'd50, 7'd50, 2'd3, 2'd3, 9'd7, 1, 4'd15, 5'd0);
    issue("R1 op none");
    chk("R1 none const", disp_o, 32'h0000_0123);
    // R7/R3: plain D-form sign extension
    set_fields(16'h8000, 0, 2'd0, 2'd1, 7'd5, 7'd0, 2'd0, 2'd0, 9'd0, 0, 4'd4, 5'd0);
    issue("R3 plain");
    chk("R3 plain const", disp_o, 32'hFFFF_8000);
    // R4: max shift
    set_fields(16'h0001, 0, 2'd3, 2'd2, 7'd0, 7'd1, 2'd0, 2'd0, 9'd0, 0, 4'd0, 5'd31);
    issue("R4 max shift");
    chk("R4 max const", disp_o, 32'h8000_0000);

    // R10: idle cycle with changed inputs
    held = disp_o;
    valid_i = 1'b0;
    set_fields(16'h1234, 0, 2'd1, 2'd1, 7'd7, 7'd7, 2'd1, 2'd1, 9'd0, 0, 4'd2, 5'd0);
    @(negedge clk);
    chk("R9 idle valid", 32'(valid_o), 32'd0);
    chk("R10 hold disp", disp_o, held);
    chk("R10 hold replace", 32'(replace_o), 32'd1);

    for (int i = 0; i < 3000; i++) begin
      randomize_fields();
      if ($urandom % 8 == 0) begin
        held = disp_o;
        valid_i = 1'b0;
        @(negedge clk);
        chk("R10 hold rand", disp_o, held);
      end else begin
        issue(tag_of());
        valid_i = 1'b0;
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule